// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block sends words over a single asynchronous serial line. A host places a word into a one-entry holding buffer with a write strobe. When the output stage is free, the word moves into a shift register, and the line then carries the whole frame: a start bit, the data bits, an optional parity bit and the stop bits. The data length, the parity mode and the stop count are configuration inputs. They are read at the moment a word enters the shift register, so they may change while a frame is on the line.

The only time base is a per-cycle enable, `tick_en`, pulsed at sixteen times the bit rate, which is the rate a matching oversampling receiver uses. Every bit lasts sixteen of these ticks. Because the buffer is separate from the shift register, the host can queue the next word while the current frame is still going out, and frames then follow each other with no idle time between them.

Two flags tell the host where things stand. `buf_empty` means another word can be written. `tx_done` means the line has gone quiet with nothing left to send.

Top module: `sertx_top`

## Requirements
- R1: After reset the line `txd` is high, `buf_empty` is 1 and `tx_done` is 0. The line stays high whenever no frame is being sent.
- R2: A frame starts with one low bit, and the data follows least significant bit first. Each bit, the start bit included, lasts exactly 16 cycles in which `tick_en` is high. The start bit appears on the line one cycle after the word enters the shift register.
- R3: `cfg_len` selects the data length: 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits. Codes 5 to 7 give 9 bits.
- R4: `cfg_par` selects the parity: 00 or 01 sends no parity bit, 10 sends even parity and 11 sends odd parity. The parity bit comes right after the last data bit and covers only the data bits that are sent.
- R5: `cfg_stop2` = 0 ends the frame with one high stop bit, and `cfg_stop2` = 1 ends it with two.
- R6: The configuration is taken on the cycle a word moves from the buffer into the shift register. Changing it later has no effect on that frame.
- R7: A write with `wr_en` high while `buf_empty` is 1 is accepted, and `buf_empty` reads 0 from the next cycle. A write while `buf_empty` is 0 is ignored: the word is never sent. `buf_empty` returns to 1 one cycle after the buffered word enters the shift register.
- R8: If the buffer holds a word when the last stop bit ends, the start bit of the next frame follows on the very next cycle. There is no idle bit time between the two frames.
- R9: `tx_done` becomes 1 one cycle after the last stop bit ends with the buffer empty. It returns to 0 one cycle after the next accepted write.
- R10: While `tick_en` is low, the current bit is held on the line and its duration count does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 16x bit-rate enable |
| cfg_len | input | 3 | Data length code (5 + code bits, at most 9) |
| cfg_par | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send, bit 0 sent first |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer can accept a word |
| tx_done | output | 1 | Line idle with nothing pending |

## Verification
The assertions check on every cycle that the line is high whenever the output stage is idle and that every frame opens with a low bit. They also check that an ignored write leaves the buffered word untouched, that the buffer reports empty right after a transfer, and that a queued word starts on the cycle after a frame ends. Two more hold on every cycle: the line never moves on a cycle without a tick unless a new frame loads, and `tx_done` only shows while the line is idle and the buffer empty. The remaining behaviours can only be shown by the bench's scenarios. These are the exact bit sequence for each length, parity and stop combination, the parity values themselves, and the capture of the configuration at load time. The bench also covers the fate of a word written into a full buffer and the cycle on which `tx_done` appears.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Longest data field and the frame that follows the start bit
    localparam int MAX_DATA   = 9;
    localparam int MIN_DATA   = 5;
    localparam int FRAME_W    = MAX_DATA + 3;   // data + parity + two stop bits
    localparam int NB_W       = 4;              // holds a bit count up to FRAME_W
    localparam int OVERSAMPLE = 16;

    typedef enum logic [1:0] {
        PAR_OFF     = 2'b00,
        PAR_OFF_ALT = 2'b01,
        PAR_EVEN    = 2'b10,
        PAR_ODD     = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [2:0] len_code;
        par_mode_e  par;
        logic       stop2;
    } frame_cfg_t;

    // Bits after the start bit, first to go out in bit 0
    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
    } frame_t;

    function automatic int data_len(logic [2:0] code);
        int n;
        n = MIN_DATA + int'(code);
        if (n > MAX_DATA) n = MAX_DATA;
        return n;
    endfunction

    function automatic frame_t build_frame(logic [MAX_DATA-1:0] d, frame_cfg_t c);
        frame_t f;
        int     n;
        int     pos;
        logic   acc;
        n      = data_len(c.len_code);
        f.bits = '1;
        acc    = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) begin
                f.bits[i] = d[i];
                acc       = acc ^ d[i];
            end
        end
        pos = n;
        if (c.par[1]) begin
            f.bits[pos] = c.par[0] ? ~acc : acc;
            pos         = pos + 1;
        end
        // stop bits are the ones already filled in above
        pos     = pos + (c.stop2 ? 2 : 1);
        f.nbits = NB_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic                take,
    output logic                full,
    output logic [MAX_DATA-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
        end else begin
            if (take) full <= 1'b0;
            if (wr_en && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

    // R7: a write into an occupied buffer leaves its word in place
    a_r7_ignore_when_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !take) |=> (full && $stable(data)));

endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic tick_en,
    output logic bit_end
);

    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    assign bit_end = run && tick_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && tick_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   bit_end,
    output logic   busy,
    output logic   txd,
    output logic   frame_end
);

    logic [FRAME_W-1:0] sr;
    logic [NB_W-1:0]    rem;

    assign frame_end = busy && bit_end && (rem == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            sr   <= '1;
            rem  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            txd  <= 1'b0;
            sr   <= frame_in.bits;
            rem  <= frame_in.nbits;
        end else if (frame_end) begin
            busy <= 1'b0;
            txd  <= 1'b1;
        end else if (busy && bit_end) begin
            txd  <= sr[0];
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            rem  <= rem - 1'b1;
        end
    end

    // R1: the line rests high when no frame is being sent
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R2: a frame opens with a low bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OSR = OVERSAMPLE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic [2:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_stop2,
    input  logic                wr_en,
    input  logic [MAX_DATA-1:0] wr_data,
    output logic                txd,
    output logic                buf_empty,
    output logic                tx_done
);

    logic                hb_full;
    logic [MAX_DATA-1:0] hb_data;
    logic                busy;
    logic                bit_end;
    logic                frame_end;
    logic                load;
    frame_cfg_t          cfg_now;
    frame_t              next_frame;

    always_comb begin
        cfg_now.len_code = cfg_len;
        cfg_now.par      = par_mode_e'(cfg_par);
        cfg_now.stop2    = cfg_stop2;
        next_frame       = build_frame(hb_data, cfg_now);
    end

    // a waiting word moves in when the stage is free or just finishing
    assign load = hb_full && (!busy || frame_end);

    sertx_holdbuf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (hb_full),
        .data    (hb_data)
    );

    sertx_bitclk #(.OSR(OSR)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .run     (busy),
        .tick_en (tick_en),
        .bit_end (bit_end)
    );

    sertx_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .frame_in  (next_frame),
        .bit_end   (bit_end),
        .busy      (busy),
        .txd       (txd),
        .frame_end (frame_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done <= 1'b0;
        end else if (wr_en && !hb_full) begin
            tx_done <= 1'b0;
        end else if (frame_end && !hb_full) begin
            tx_done <= 1'b1;
        end
    end

    assign buf_empty = !hb_full;

    // R7: the buffer reports empty once its word has moved on
    a_r7_empty_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> buf_empty);

    // R8: a queued word starts straight after the previous frame
    a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !buf_empty) |=> (!txd && busy));

    // R9: completion only shows while the line is quiet and nothing waits
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (buf_empty && txd));

    // R10: without a tick the line holds unless a new frame loads
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_en && !load) |=> $stable(txd));

endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [2:0] cfg_len = 3'd3;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd;
    logic       buf_empty;
    logic       tx_done;

    int checks = 0;
    int failures = 0;
    int tick_div = 1;
    int cyc = 0;

    always #2 clk = ~clk;

    sertx_top uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cfg_len   (cfg_len),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .txd       (txd),
        .buf_empty (buf_empty),
        .tx_done   (tx_done)
    );

    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            tick_en = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected bits after the start bit and total bit count of a frame
    function automatic void mk(input logic [8:0] d, input int lc, input int pm,
                               input int s2, output logic [12:0] bits,
                               output int total);
        int   n;
        logic p;
        n = (lc > 4) ? 9 : 5 + lc;
        bits = '1;
        p = 1'b0;
        for (int i = 0; i < n; i++) begin
            bits[i] = d[i];
            p = p ^ d[i];
        end
        if (pm >= 2) bits[n] = (pm == 3) ? ~p : p;
        total = 1 + n + ((pm >= 2) ? 1 : 0) + 1 + s2;
    endfunction

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Follows one frame by counting ticks; samples each bit at its middle
    // and returns at the negedge after the tick that ends the frame.
    task automatic recv(input logic [12:0] bits, input int total,
                        input bit wait_start, input string req);
        int ticks;
        int guard;
        logic expv;
        if (wait_start) begin
            guard = 0;
            while (txd !== 1'b0 && guard < 4000) begin
                @(negedge clk);
                guard = guard + 1;
            end
            chk(txd === 1'b0, "R2", "start bit not seen", int'(txd), 0);
        end
        ticks = 0;
        for (int k = 0; k < total; k++) begin
            while (ticks < 16 * k + 8) begin
                @(posedge clk);
                if (tick_en) ticks = ticks + 1;
            end
            @(negedge clk);
            expv = (k == 0) ? 1'b0 : bits[k-1];
            chk(txd === expv, req, $sformatf("bit %0d of %0d", k, total),
                int'(txd), int'(expv));
        end
        while (ticks < 16 * total) begin
            @(posedge clk);
            if (tick_en) ticks = ticks + 1;
        end
        @(negedge clk);
    endtask

    // Single frame from an idle block, with flag timing around it
    task automatic send_one(input logic [8:0] d, input int lc, input int pm,
                            input int s2, input string req);
        logic [12:0] bits;
        int total;
        mk(d, lc, pm, s2, bits, total);
        cfg_len = 3'(lc);
        cfg_par = 2'(pm);
        cfg_stop2 = s2[0];
        wr(d);
        chk(buf_empty === 1'b0, "R7", "buf_empty after write", int'(buf_empty), 0);
        chk(tx_done === 1'b0, "R9", "tx_done after write", int'(tx_done), 0);
        @(negedge clk);
        chk(buf_empty === 1'b1, "R7", "buf_empty after load", int'(buf_empty), 1);
        chk(txd === 1'b0, "R2", "start one cycle after load", int'(txd), 0);
        recv(bits, total, 1'b0, req);
        chk(tx_done === 1'b1, "R9", "tx_done after last stop", int'(tx_done), 1);
        chk(txd === 1'b1, "R1", "line high after frame", int'(txd), 1);
    endtask

    initial begin
        logic [12:0] ba;
        logic [12:0] bb;
        int ta;
        int tb;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(buf_empty === 1'b1, "R1", "buf_empty after reset", int'(buf_empty), 1);
        chk(tx_done === 1'b0, "R1", "tx_done after reset", int'(tx_done), 0);

        // R3 R4 R5: every length, parity mode and stop count
        for (int lc = 0; lc < 5; lc++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int s2 = 0; s2 < 2; s2++) begin
                    int pm;
                    pm = (pi == 0) ? 0 : pi + 1;
                    send_one(9'((lc * 73 + pm * 29 + s2 * 151 + 165) & 511),
                             lc, pm, s2, "R3/R4/R5 sweep");
                end
            end
        end

        // R4: extreme data patterns for both parities, and code 01 = none
        send_one(9'h000, 4, 2, 0, "R4 even zeros");
        send_one(9'h000, 4, 3, 0, "R4 odd zeros");
        send_one(9'h1FF, 4, 2, 1, "R4 even ones");
        send_one(9'h1FF, 4, 3, 1, "R4 odd ones");
        send_one(9'h0B6, 3, 1, 0, "R4 mode 01 no parity");

        // R3: codes above 4 send nine bits
        send_one(9'h13C, 6, 2, 0, "R3 clamp code 6");

        // R6: configuration changed right after load does not apply
        mk(9'h1A5, 4, 3, 1, ba, ta);
        cfg_len = 3'd4;
        cfg_par = 2'b11;
        cfg_stop2 = 1'b1;
        wr(9'h1A5);
        @(negedge clk);
        cfg_len = 3'd0;
        cfg_par = 2'b00;
        cfg_stop2 = 1'b0;
        recv(ba, ta, 1'b1, "R6 captured config");
        chk(tx_done === 1'b1, "R6", "tx_done at captured length", int'(tx_done), 1);

        // R7 R8: queued word goes out back to back; a write into a full buffer is lost
        cfg_len = 3'd3;
        cfg_par = 2'b00;
        cfg_stop2 = 1'b0;
        mk(9'h0C3, 3, 0, 0, ba, ta);
        mk(9'h05A, 3, 0, 0, bb, tb);
        wr(9'h0C3);
        @(negedge clk);
        fork
            recv(ba, ta, 1'b1, "R8 first frame");
            begin
                repeat (20) @(negedge clk);
                wr(9'h05A);
                chk(buf_empty === 1'b0, "R7", "buffer full during frame", int'(buf_empty), 0);
                wr(9'h0FF);
                chk(buf_empty === 1'b0, "R7", "still full after ignored write", int'(buf_empty), 0);
            end
        join
        chk(txd === 1'b0, "R8", "next start without gap", int'(txd), 0);
        chk(tx_done === 1'b0, "R8", "no done between frames", int'(tx_done), 0);
        chk(buf_empty === 1'b1, "R7", "buffer empty after second load", int'(buf_empty), 1);
        recv(bb, tb, 1'b0, "R8 second frame");
        chk(tx_done === 1'b1, "R9", "done after second frame", int'(tx_done), 1);
        repeat (200) @(negedge clk);
        chk(txd === 1'b1, "R7", "ignored word never sent", int'(txd), 1);
        chk(tx_done === 1'b1, "R9", "done holds while idle", int'(tx_done), 1);

        // R10: sparse ticks stretch every bit
        tick_div = 3;
        send_one(9'h0A9, 3, 2, 0, "R10 sparse ticks");
        tick_div = 5;
        send_one(9'h117, 4, 3, 1, "R10 sparser ticks");
        tick_div = 1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule